// File: doc/BRIEF.md
# Machine Cycle State Sequencer

This block turns an oscillator-rate clock into machine cycles for a simple byte-oriented processor core. Every machine cycle is split into six states, S1 through S6, and each state is two oscillator clocks long: phase P1 comes first, then P2. One machine cycle is therefore twelve clocks. The sequencer shows the current state and phase and marks the end of every machine cycle. It also issues the code-fetch strobes for the instruction that is running.

The opcode is latched in S1 of an instruction's first machine cycle. A second code fetch is strobed in S4 of every machine cycle. That fetch advances the program counter only in the first cycle, and only when the instruction really needs a second code byte. In every other case the fetched byte is discarded. An external data move always lasts two machine cycles, and its second cycle makes no code fetch at all.

The decoder presents the next instruction's attributes: a cycle-count code, a second-byte flag and an external-move flag. The sequencer samples them in the last clock of the current instruction.

Top module: `mcs_sequencer`

## Requirements
- R1: In reset and in the first clock after reset, the state is S1 and the phase is P1, with `opc_latch` and `pc_inc` high. The first instruction after reset is treated as one machine cycle long, needing no second byte and not an external move.
- R2: `state_o` counts 0 to 5 (S1 to S6) and then wraps. `phase_o` is 0 for P1 and 1 for P2. Each state holds for exactly two clocks, P1 then P2, so a machine cycle is 12 clocks.
- R3: `opc_latch` is high for one clock, at S1 P1 of an instruction's first machine cycle, and at no other time.
- R4: `fetch2` is high for one clock at S4 P1 of every machine cycle, except in the case given in R6.
- R5: `pc_inc` is high with every `opc_latch`. It is also high with `fetch2` in the first machine cycle when the second-byte flag was set. Every other `fetch2` leaves `pc_inc` low.
- R6: An instruction flagged as an external move lasts two machine cycles whatever its cycle code. `fetch2` stays low for the whole of its second cycle.
- R7: The cycle code sets the instruction length: 0 gives 1 machine cycle, 1 gives 2, and 2 or 3 gives 4.
- R8: `mc_pulse` is high for one clock at S6 P2 of every machine cycle.
- R9: `eoi` is high for one clock at S6 P2 of an instruction's last machine cycle, and the next clock is S1 P1 with `opc_latch` high. The attribute inputs are sampled only at that clock, so changing them at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_code | input | 2 | Cycle-count code of the next instruction |
| need_byte2 | input | 1 | Next instruction needs a second code byte |
| ext_move | input | 1 | Next instruction is an external data move |
| state_o | output | 3 | Current state, 0 to 5 for S1 to S6 |
| phase_o | output | 1 | Current phase, 0 for P1 and 1 for P2 |
| opc_latch | output | 1 | Opcode-latch strobe |
| fetch2 | output | 1 | Second code-fetch strobe |
| pc_inc | output | 1 | Program-counter increment enable |
| mc_pulse | output | 1 | End-of-machine-cycle pulse |
| eoi | output | 1 | End-of-instruction pulse |

## Verification
The bench targets these corner cases:

- **External move with a four-cycle code.** The move must still end after two cycles. A design that lets the cycle code win would run four cycles and keep fetching.
- **External move's second cycle.** A design that does not gate that cycle would raise `fetch2` there.
- **Second fetches in later cycles of a multi-cycle instruction.** These must not advance the PC. A design that ignores the cycle index would raise `pc_inc` on them.
- **Attribute inputs changed mid-instruction.** A design that samples outside `eoi` would pick up the wrong length or the wrong fetch behaviour.
- **Reset in the middle of a long instruction.** It must return the sequencer to S1 with a one-cycle first instruction.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int unsigned STATES    = 6;
  localparam int unsigned PHASES    = 2;
  localparam int unsigned MAXCYC    = 4;
  localparam int unsigned FETCH2_ST = 3;   // S4
  localparam int unsigned SW = $clog2(STATES);
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam int unsigned CW = $clog2(MAXCYC);

  typedef enum logic [1:0] {
    LEN_ONE  = 2'd0,
    LEN_TWO  = 2'd1,
    LEN_FOUR = 2'd2,
    LEN_FOUR_ALT = 2'd3
  } len_code_e;

  // index of the final machine cycle of an instruction
  function automatic logic [CW-1:0] final_cycle(input logic [1:0] code, input logic ext);
    logic [CW-1:0] r;
    if (ext) r = CW'(1);
    else begin
      case (len_code_e'(code))
        LEN_ONE: r = CW'(0);
        LEN_TWO: r = CW'(1);
        default: r = CW'(MAXCYC - 1);
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/mcs_state_gen.sv
module mcs_state_gen
  import mcs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] state,
  output logic [PW-1:0] phase,
  output logic          mc_end
);
  logic last_phase;
  logic last_state;

  assign last_phase = (phase == PW'(PHASES - 1));
  assign last_state = (state == SW'(STATES - 1));
  assign mc_end     = last_phase && last_state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      state <= '0;
    end else if (last_phase) begin
      phase <= '0;
      state <= last_state ? '0 : state + SW'(1);
    end else begin
      phase <= phase + PW'(1);
    end
  end
endmodule

// File: rtl/mcs_cycle_ctr.sv
module mcs_cycle_ctr
  import mcs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mc_end,
  input  logic [1:0]    cyc_code,
  input  logic          need_byte2,
  input  logic          ext_move,
  output logic [CW-1:0] mc_idx,
  output logic          last_mc,
  output logic          need2_q,
  output logic          ext_q
);
  logic [CW-1:0] final_q;

  assign last_mc = (mc_idx == final_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc_idx  <= '0;
      final_q <= '0;
      need2_q <= 1'b0;
      ext_q   <= 1'b0;
    end else if (mc_end) begin
      if (last_mc) begin
        mc_idx  <= '0;
        final_q <= final_cycle(cyc_code, ext_move);
        need2_q <= need_byte2;
        ext_q   <= ext_move;
      end else begin
        mc_idx <= mc_idx + CW'(1);
      end
    end
  end
endmodule

// File: rtl/mcs_strobe_dec.sv
module mcs_strobe_dec
  import mcs_pkg::*;
(
  input  logic [SW-1:0] state,
  input  logic [PW-1:0] phase,
  input  logic          mc_end,
  input  logic [CW-1:0] mc_idx,
  input  logic          last_mc,
  input  logic          need2_q,
  input  logic          ext_q,
  output logic          opc_latch,
  output logic          fetch2,
  output logic          pc_inc,
  output logic          mc_pulse,
  output logic          eoi
);
  logic first_mc;
  logic s4_p1;
  logic fetch_skip;

  assign first_mc   = (mc_idx == '0);
  assign s4_p1      = (state == SW'(FETCH2_ST)) && (phase == '0);
  assign fetch_skip = ext_q && (mc_idx == CW'(1));

  always_comb begin
    opc_latch = first_mc && (state == '0) && (phase == '0);
    fetch2    = s4_p1 && !fetch_skip;
    pc_inc    = opc_latch || (fetch2 && first_mc && need2_q);
    mc_pulse  = mc_end;
    eoi       = mc_end && last_mc;
  end
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cyc_code,
  input  logic          need_byte2,
  input  logic          ext_move,
  output logic [SW-1:0] state_o,
  output logic [PW-1:0] phase_o,
  output logic          opc_latch,
  output logic          fetch2,
  output logic          pc_inc,
  output logic          mc_pulse,
  output logic          eoi
);
  logic          mc_end;
  logic [CW-1:0] mc_idx;
  logic          last_mc;
  logic          need2_q;
  logic          ext_q;

  mcs_state_gen i_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state_o),
    .phase  (phase_o),
    .mc_end (mc_end)
  );

  mcs_cycle_ctr i_cyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_end     (mc_end),
    .cyc_code   (cyc_code),
    .need_byte2 (need_byte2),
    .ext_move   (ext_move),
    .mc_idx     (mc_idx),
    .last_mc    (last_mc),
    .need2_q    (need2_q),
    .ext_q      (ext_q)
  );

  mcs_strobe_dec i_dec (
    .state     (state_o),
    .phase     (phase_o),
    .mc_end    (mc_end),
    .mc_idx    (mc_idx),
    .last_mc   (last_mc),
    .need2_q   (need2_q),
    .ext_q     (ext_q),
    .opc_latch (opc_latch),
    .fetch2    (fetch2),
    .pc_inc    (pc_inc),
    .mc_pulse  (mc_pulse),
    .eoi       (eoi)
  );
endmodule

// File: rtl/mcs_sequencer_chk.sv
module mcs_sequencer_chk
  import mcs_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] state_o,
  input logic [PW-1:0] phase_o,
  input logic          opc_latch,
  input logic          fetch2,
  input logic          pc_inc,
  input logic          mc_pulse,
  input logic          eoi,
  input logic [CW-1:0] mc_idx,
  input logic          ext_q
);
  a_r2_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_o != $past(phase_o)));
  a_r2_state_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    state_o < SW'(STATES));
  a_r3_latch_in_s1: assert property (@(posedge clk) disable iff (!rst_n)
    opc_latch |-> (state_o == '0 && phase_o == '0 && mc_idx == '0));
  a_r4_fetch_in_s4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch2 |-> (state_o == SW'(FETCH2_ST) && phase_o == '0));
  a_r5_inc_only_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |-> (opc_latch || fetch2));
  a_r6_no_fetch_ext_second: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && mc_idx == CW'(1)) |-> !fetch2);
  a_r6_ext_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q |-> mc_idx <= CW'(1));
  a_r8_pulse_at_s6p2: assert property (@(posedge clk) disable iff (!rst_n)
    mc_pulse |-> (state_o == SW'(STATES - 1) && phase_o == PW'(PHASES - 1)));
  a_r9_eoi_then_latch: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> opc_latch);
  a_r9_eoi_on_cycle_end: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |-> mc_pulse);
endmodule

bind mcs_sequencer mcs_sequencer_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state_o   (state_o),
  .phase_o   (phase_o),
  .opc_latch (opc_latch),
  .fetch2    (fetch2),
  .pc_inc    (pc_inc),
  .mc_pulse  (mc_pulse),
  .eoi       (eoi),
  .mc_idx    (mc_idx),
  .ext_q     (ext_q)
);

// File: tb/test_mcs_sequencer.sv
module test_mcs_sequencer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cyc_code = 2'd0;
  logic       need_byte2 = 1'b0;
  logic       ext_move = 1'b0;
  logic [2:0] state_o;
  logic [0:0] phase_o;
  logic       opc_latch, fetch2, pc_inc, mc_pulse, eoi;

  mcs_sequencer i_mcs_sequencer (
    .clk(clk), .rst_n(rst_n), .cyc_code(cyc_code), .need_byte2(need_byte2),
    .ext_move(ext_move), .state_o(state_o), .phase_o(phase_o),
    .opc_latch(opc_latch), .fetch2(fetch2), .pc_inc(pc_inc),
    .mc_pulse(mc_pulse), .eoi(eoi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit comparing = 0;

  // behavioural reference: clock count within a machine cycle, cycle index,
  // instruction length in machine cycles and its flags
  int m_tick = 0, m_mc = 0, m_len = 1;
  bit m_n2 = 0, m_ex = 0;
  int eoi_seen = 0;
  int mismatch_latch = 0;

  function automatic int len_of(input int code, input bit ex);
    if (ex) return 2;
    if (code == 0) return 1;
    if (code == 1) return 2;
    return 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_tick = 0; m_mc = 0; m_len = 1; m_n2 = 0; m_ex = 0;
    end else if (m_tick == 11) begin
      m_tick = 0;
      if (m_mc == m_len - 1) begin
        m_mc = 0;
        m_len = len_of(cyc_code, ext_move);
        m_n2 = need_byte2;
        m_ex = ext_move;
      end else m_mc++;
    end else m_tick++;
  end

  function automatic bit e_opc();  return m_mc == 0 && m_tick == 0; endfunction
  function automatic bit e_f2();   return m_tick == 6 && !(m_ex && m_mc == 1); endfunction
  function automatic bit e_eoi();  return m_tick == 11 && m_mc == m_len - 1; endfunction

  always @(negedge clk) begin
    if (comparing) begin
      chk("R2 state",  int'(state_o), m_tick / 2);
      chk("R2 phase",  int'(phase_o), m_tick % 2);
      chk("R3 opc_latch", int'(opc_latch), int'(e_opc()));
      chk("R4/R6 fetch2", int'(fetch2), int'(e_f2()));
      chk("R5 pc_inc", int'(pc_inc),
          int'(e_opc() || (e_f2() && m_mc == 0 && m_n2)));
      chk("R8 mc_pulse", int'(mc_pulse), int'(m_tick == 11));
      chk("R7/R9 eoi", int'(eoi), int'(e_eoi()));
      if (e_eoi()) eoi_seen++;
    end
  end

  // run one instruction with given attributes; inputs are scrambled between samples
  task automatic run_instr(input int code, input bit n2, input bit ex);
    int len, cnt;
    len = len_of(code, ex);
    cnt = 0;
    while (!e_eoi()) @(negedge clk);
    cyc_code = 2'(code); need_byte2 = n2; ext_move = ex;
    @(negedge clk);
    cyc_code = 2'($urandom); need_byte2 = 1'($urandom); ext_move = 1'($urandom);
    // count clocks until its own end
    cnt = 1;
    while (!eoi) begin @(negedge clk); cnt++; end
    chk("R7/R6 instr length", cnt, 12 * len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", int'(state_o), 0);
    chk("R1 reset opc_latch", int'(opc_latch), 1);
    chk("R1 reset pc_inc", int'(pc_inc), 1);
    rst_n = 1'b1;
    comparing = 1;
    // first instruction after reset is one cycle long
    chk("R1 first eoi delay pre", int'(eoi), 0);
    for (int k = 0; k < 11; k++) @(negedge clk);
    chk("R1 first instr one cycle", int'(eoi), 1);
    run_instr(0, 0, 0);
    run_instr(0, 1, 0);
    run_instr(1, 0, 0);
    run_instr(1, 1, 0);
    run_instr(2, 1, 0);
    run_instr(3, 0, 0);
    run_instr(0, 0, 1);
    run_instr(3, 1, 1);
    run_instr(2, 0, 1);
    for (int k = 0; k < 12; k++) run_instr(k % 4, 1'(k / 2), 1'(k / 3));
    // reset in the middle of a long instruction
    run_instr(3, 1, 0);
    while (!e_eoi()) @(negedge clk);
    cyc_code = 2'd3; need_byte2 = 1'b1; ext_move = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    comparing = 0;
    @(negedge clk);
    chk("R1 mid reset state", int'(state_o), 0);
    chk("R1 mid reset opc_latch", int'(opc_latch), 1);
    rst_n = 1'b1;
    comparing = 1;
    for (int k = 0; k < 11; k++) @(negedge clk);
    chk("R1 one cycle after reset", int'(eoi), 1);
    run_instr(1, 1, 0);
    run_instr(0, 0, 0);
    repeat (13) @(negedge clk);
    chk("R9 eoi count", int'(eoi_seen > 25), 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule